// File: doc/BRIEF.md
# Time-Shared Second-Order Recurrence Engine

This block evaluates the linear recurrence Z[n] = A·Z[n-2] + B·Z[n-1] + C. Each iteration takes one set of operands and returns one result. There is one multiply/add operator, and a short fixed sequencer reuses it for every term. The operator reads two operand registers. Its results collect in an accumulator register, and a temporary register saves the first product while the second one is being formed. Two history registers hold the latest result and the one before it. These two registers are the only state that carries from one iteration to the next.

The user offers operands with `in_valid` while `in_ready` is high. The engine then runs five internal steps, one clock each:

1. Multiply A by the older result.
2. Park that product, then multiply B by the newer result.
3. Add C.
4. Add the parked product.
5. Shift the history registers and present the result.

The result appears on `z_out`, marked by a one-cycle `z_valid` pulse. All arithmetic wraps modulo 2^DW, which is the same as two's-complement truncation. A synchronous reset sets both history registers to zero and returns the sequencer to idle.

Top module: `recur2_core`

## Requirements
- R1: While `rst` is high at a rising edge, the engine goes idle. After that edge `in_ready` is 1 and `z_valid` is 0, and both history values are zero, so the next result equals that iteration's C.
- R2: Operands are taken at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 for the next five cycles, and operand values and `in_valid` seen during those cycles have no effect.
- R3: For operands taken at edge n, `z_valid` is 1 only in the cycle after edge n+5. It is 0 in every other cycle, so no two consecutive cycles have it high.
- R4: The result is ((A·Z[n-2]) + (B·Z[n-1]) + C) mod 2^DW, with Z[-1] = Z[-2] = 0.
- R5: When a result is produced, the older history value takes the previous newer value, and the newer history value takes the new result. Between results both hold.
- R6: A single iteration can exceed 2^DW in its products and sums. The result is the low DW bits, for example 2·0x8000 + 1 = 0x0001 at DW = 16.
- R7: A reset during an iteration cancels it. No `z_valid` follows, and the next iteration sees zero history.
- R8: `z_out` changes only in a cycle where `z_valid` is 1, and keeps its value otherwise.
- R9: While idle with `in_valid` low, nothing changes: `z_valid` stays 0 and the next accepted iteration uses the same history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands offered |
| a_in | input | DW | Coefficient for the result two iterations back |
| b_in | input | DW | Coefficient for the previous result |
| c_in | input | DW | Additive constant |
| in_ready | output | 1 | Engine idle, operands can be taken |
| z_out | output | DW | Latest result |
| z_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench checks the history ordering with a Fibonacci-style run and with random streams. A design that swapped the two history registers, or forgot to park the first product, would give wrong terms after the second iteration. While the engine is busy, the bench changes the operands and holds `in_valid` high. Any design that re-read its inputs after acceptance, or accepted a second job, would either corrupt the result or show an extra `z_valid` pulse. The bench also applies a reset in the middle of an iteration, and drives operands that overflow the product and the sum. These catch a design that lets a cancelled iteration finish, keeps old history after reset, or saturates where it should wrap.

// File: rtl/recur2_pkg.sv
package recur2_pkg;

  // Sequencer positions; each busy position lasts exactly one clock.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_A,
    ST_MUL_B,
    ST_ADD_C,
    ST_ADD_T,
    ST_COMMIT
  } step_t;

  // Source selection for the first operand register.
  typedef enum logic [1:0] {
    X1_FROM_A,
    X1_FROM_B,
    X1_FROM_C,
    X1_FROM_T
  } x1_src_t;

  // Source selection for the second operand register.
  typedef enum logic [1:0] {
    X2_FROM_OLD,
    X2_FROM_NEW,
    X2_FROM_FWD
  } x2_src_t;

  typedef enum logic {
    OP_MUL,
    OP_ADD
  } op_t;

  typedef struct packed {
    logic    ld_x;
    x1_src_t x1_src;
    x2_src_t x2_src;
    op_t     op;
    logic    wr_y;
    logic    wr_t;
    logic    commit;
  } ctrl_t;

  localparam int unsigned BUSY_STEPS = 5;

endpackage

// File: rtl/recur2_seq.sv
module recur2_seq
  import recur2_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output logic  in_ready,
  output logic  accept,
  output step_t step,
  output ctrl_t ctrl
);

  step_t step_q;
  step_t step_d;

  assign in_ready = (step_q == ST_IDLE);
  assign accept   = in_ready && in_valid;
  assign step     = step_q;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:   if (accept) step_d = ST_MUL_A;
      ST_MUL_A:  step_d = ST_MUL_B;
      ST_MUL_B:  step_d = ST_ADD_C;
      ST_ADD_C:  step_d = ST_ADD_T;
      ST_ADD_T:  step_d = ST_COMMIT;
      ST_COMMIT: step_d = ST_IDLE;
      default:   step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  // Control word per step. Operand loads in one step feed the shared
  // unit in the next, so each step loads the operands of the following one.
  always_comb begin
    ctrl        = '0;
    ctrl.x1_src = X1_FROM_A;
    ctrl.x2_src = X2_FROM_OLD;
    ctrl.op     = OP_MUL;
    unique case (step_q)
      ST_IDLE: begin
        ctrl.ld_x   = accept;
        ctrl.x1_src = X1_FROM_A;
        ctrl.x2_src = X2_FROM_OLD;
        ctrl.op     = OP_MUL;
      end
      ST_MUL_A: begin
        ctrl.wr_y   = 1'b1;
        ctrl.ld_x   = 1'b1;
        ctrl.x1_src = X1_FROM_B;
        ctrl.x2_src = X2_FROM_NEW;
        ctrl.op     = OP_MUL;
      end
      ST_MUL_B: begin
        ctrl.wr_y   = 1'b1;
        ctrl.wr_t   = 1'b1;
        ctrl.ld_x   = 1'b1;
        ctrl.x1_src = X1_FROM_C;
        ctrl.x2_src = X2_FROM_FWD;
        ctrl.op     = OP_ADD;
      end
      ST_ADD_C: begin
        ctrl.wr_y   = 1'b1;
        ctrl.ld_x   = 1'b1;
        ctrl.x1_src = X1_FROM_T;
        ctrl.x2_src = X2_FROM_FWD;
        ctrl.op     = OP_ADD;
      end
      ST_ADD_T: begin
        ctrl.wr_y   = 1'b1;
      end
      ST_COMMIT: begin
        ctrl.commit = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/recur2_opunit.sv
module recur2_opunit
  import recur2_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  op_t          op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] res
);

  localparam int unsigned PW = 2 * DW;

  // Full product, then keep the low DW bits (modular wraparound).
  function automatic logic [DW-1:0] wrap_mul(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    logic [PW-1:0] full;
    full = PW'(x) * PW'(y);
    return full[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    logic [DW:0] full;
    full = {1'b0, x} + {1'b0, y};
    return full[DW-1:0];
  endfunction

  always_comb begin
    unique case (op)
      OP_MUL:  res = wrap_mul(opa, opb);
      OP_ADD:  res = wrap_add(opa, opb);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/recur2_dpath.sv
module recur2_dpath
  import recur2_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl,
  input  logic          accept,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  output logic [DW-1:0] y_acc,
  output logic [DW-1:0] hist_new,
  output logic [DW-1:0] hist_old,
  output logic [DW-1:0] z_out,
  output logic          z_valid
);

  logic [DW-1:0] b_hold, c_hold;
  logic [DW-1:0] x1_q, x2_q;
  logic [DW-1:0] t_q, y_q;
  logic [DW-1:0] y1_q, y2_q;
  logic [DW-1:0] unit_res;
  logic [DW-1:0] x1_d, x2_d;
  op_t           op_q;

  recur2_opunit #(.DW(DW)) u_unit (
    .op  (op_q),
    .opa (x1_q),
    .opb (x2_q),
    .res (unit_res)
  );

  // B and C are captured at acceptance so the ports are free while busy.
  always_ff @(posedge clk) begin
    if (accept) begin
      b_hold <= b_in;
      c_hold <= c_in;
    end
  end

  always_comb begin
    unique case (ctrl.x1_src)
      X1_FROM_A: x1_d = a_in;
      X1_FROM_B: x1_d = b_hold;
      X1_FROM_C: x1_d = c_hold;
      X1_FROM_T: x1_d = t_q;
      default:   x1_d = '0;
    endcase
    unique case (ctrl.x2_src)
      X2_FROM_OLD: x2_d = y2_q;
      X2_FROM_NEW: x2_d = y1_q;
      X2_FROM_FWD: x2_d = unit_res;
      default:     x2_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctrl.ld_x) begin
      x1_q <= x1_d;
      x2_q <= x2_d;
      op_q <= ctrl.op;
    end
    if (ctrl.wr_t) t_q <= y_q;
    if (ctrl.wr_y) y_q <= unit_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y1_q    <= '0;
      y2_q    <= '0;
      z_out   <= '0;
      z_valid <= 1'b0;
    end else begin
      z_valid <= ctrl.commit;
      if (ctrl.commit) begin
        y2_q  <= y1_q;
        y1_q  <= y_q;
        z_out <= y_q;
      end
    end
  end

  assign y_acc    = y_q;
  assign hist_new = y1_q;
  assign hist_old = y2_q;

endmodule

// File: rtl/recur2_core.sv
module recur2_core
  import recur2_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  output logic          in_ready,
  output logic [DW-1:0] z_out,
  output logic          z_valid
);

  // Named internal events, brought out for the checker.
  logic          accept_w;
  logic          commit_fire;
  step_t         step_w;
  ctrl_t         ctrl_w;
  logic [DW-1:0] y_acc_w, hist_new_w, hist_old_w;

  recur2_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept_w),
    .step     (step_w),
    .ctrl     (ctrl_w)
  );

  assign commit_fire = ctrl_w.commit;

  recur2_dpath #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl_w),
    .accept   (accept_w),
    .a_in     (a_in),
    .b_in     (b_in),
    .c_in     (c_in),
    .y_acc    (y_acc_w),
    .hist_new (hist_new_w),
    .hist_old (hist_old_w),
    .z_out    (z_out),
    .z_valid  (z_valid)
  );

endmodule

// File: rtl/recur2_chk.sv
module recur2_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          accept_w,
  input logic          commit_fire,
  input logic          z_valid,
  input logic [DW-1:0] z_out,
  input logic [DW-1:0] y_acc_w,
  input logic [DW-1:0] hist_new_w,
  input logic [DW-1:0] hist_old_w
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept_w |=> !in_ready);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    z_valid |=> !z_valid);

  a_r3_commit_gives_valid: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> z_valid);

  a_r3_valid_needs_commit: assert property (@(posedge clk) disable iff (rst)
    z_valid |-> $past(commit_fire));

  a_r5_history_shift: assert property (@(posedge clk) disable iff (rst)
    commit_fire |=> (hist_old_w == $past(hist_new_w)) && (hist_new_w == $past(y_acc_w)));

  a_r5_history_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(hist_new_w) && $stable(hist_old_w));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(z_out));

endmodule

bind recur2_core recur2_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .accept_w    (accept_w),
  .commit_fire (commit_fire),
  .z_valid     (z_valid),
  .z_out       (z_out),
  .y_acc_w     (y_acc_w),
  .hist_new_w  (hist_new_w),
  .hist_old_w  (hist_old_w)
);

// File: tb/sim_recur2_core.sv
`timescale 1ns/1ps
module sim_recur2_core;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] a_in = '0, b_in = '0, c_in = '0;
  logic          in_ready;
  logic [DW-1:0] z_out;
  logic          z_valid;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  // Reference history: newer and older results.
  logic [DW-1:0] m_new = '0, m_old = '0;
  logic [DW-1:0] last_z;

  always #5 clk = ~clk;

  recur2_core #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .in_ready(in_ready), .z_out(z_out), .z_valid(z_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic [DW-1:0] c);
    logic [DW-1:0] p0, p1;
    p0 = a * m_old;
    p1 = b * m_new;
    return p0 + p1 + c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_new = '0; m_old = '0;
  endtask

  // One iteration. junk: keep in_valid high with changing operands while busy.
  task automatic run_iter(input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [DW-1:0] c, input bit junk,
                          output logic [DW-1:0] got);
    logic [DW-1:0] exp;
    bit busy_ok;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", "ready before offer", {15'b0, in_ready}, 16'h1);
    chk(z_valid == 1'b0, "R3", "strobe low between results", {15'b0, z_valid}, 16'h0);
    a_in = a; b_in = b; c_in = c; in_valid = 1'b1;
    exp = model(a, b, c);
    @(posedge clk);
    busy_ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (in_ready !== 1'b0 || z_valid !== 1'b0) busy_ok = 1'b0;
      if (junk && k < 4) begin
        in_valid = 1'b1;
        a_in = DW'($urandom); b_in = DW'($urandom); c_in = DW'($urandom);
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
    end
    chk(busy_ok, "R2", "busy for five cycles, strobe low", {15'b0, busy_ok}, 16'h1);
    @(negedge clk);
    chk(z_valid == 1'b1, "R3", "strobe in cycle after edge n+5", {15'b0, z_valid}, 16'h1);
    chk(z_out == exp, "R4", "result value", z_out, exp);
    got = z_out;
    m_old = m_new; m_new = exp;
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] z;
    do_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", {15'b0, in_ready}, 16'h1);
    chk(z_valid == 1'b0, "R1", "no strobe after reset", {15'b0, z_valid}, 16'h0);
    chk(z_out == '0, "R1", "result cleared", z_out, '0);
    run_iter(16'h1234, 16'h5678, 16'h0042, 1'b0, z);
    chk(z == 16'h0042, "R1", "zero history gives C", z, 16'h0042);
  endtask

  task automatic t_fibonacci();
    logic [DW-1:0] z;
    logic [DW-1:0] fib [7] = '{16'd1, 16'd1, 16'd2, 16'd3, 16'd5, 16'd8, 16'd13};
    do_reset();
    run_iter(16'd0, 16'd0, 16'd1, 1'b0, z);
    chk(z == fib[0], "R5", "seed", z, fib[0]);
    for (int i = 1; i < 7; i++) begin
      run_iter(16'd1, 16'd1, 16'd0, 1'b0, z);
      chk(z == fib[i], "R5", "history order", z, fib[i]);
    end
    // Asymmetric weights expose swapped history slots: 3*8 + 1*13 = 37
    run_iter(16'd3, 16'd1, 16'd0, 1'b0, z);
    chk(z == 16'd37, "R5", "older slot weighted by A", z, 16'd37);
  endtask

  task automatic t_random_stream();
    logic [DW-1:0] z;
    do_reset();
    for (int i = 0; i < 40; i++)
      run_iter(DW'($urandom), DW'($urandom), DW'($urandom), 1'b0, z);
  endtask

  task automatic t_busy_ignored();
    logic [DW-1:0] z;
    do_reset();
    run_iter(16'd2, 16'd3, 16'd7, 1'b1, z);
    run_iter(16'd5, 16'd4, 16'd1, 1'b1, z);
    chk(z == 16'd29, "R2", "operands while busy ignored", z, 16'd29);
    @(negedge clk);
    chk(z_valid == 1'b0, "R3", "exactly one strobe", {15'b0, z_valid}, 16'h0);
  endtask

  task automatic t_wrap();
    logic [DW-1:0] z;
    do_reset();
    run_iter(16'd0, 16'd0, 16'h8000, 1'b0, z);
    run_iter(16'd0, 16'd2, 16'd1, 1'b0, z);
    chk(z == 16'h0001, "R6", "product wraps", z, 16'h0001);
    run_iter(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, z);
    chk(z == 16'h7FFE, "R6", "signed wrap -1 coefficients", z, 16'h7FFE);
  endtask

  task automatic t_mid_reset();
    logic [DW-1:0] z;
    bit quiet;
    do_reset();
    run_iter(16'd0, 16'd0, 16'd9, 1'b0, z);
    @(negedge clk);
    a_in = 16'd1; b_in = 16'd1; c_in = 16'd1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_new = '0; m_old = '0;
    quiet = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (z_valid !== 1'b0) quiet = 1'b0;
    end
    chk(quiet, "R7", "cancelled iteration gives no strobe", {15'b0, quiet}, 16'h1);
    run_iter(16'd4, 16'd4, 16'd3, 1'b0, z);
    chk(z == 16'd3, "R7", "history cleared by reset", z, 16'd3);
  endtask

  task automatic t_idle_hold();
    logic [DW-1:0] z;
    bit quiet;
    do_reset();
    run_iter(16'd0, 16'd0, 16'd6, 1'b0, z);
    last_z = z;
    quiet = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      a_in = DW'($urandom); b_in = DW'($urandom); c_in = DW'($urandom);
      if (z_valid !== 1'b0 || z_out !== last_z) quiet = 1'b0;
    end
    chk(quiet, "R9", "idle without offer changes nothing", {15'b0, quiet}, 16'h1);
    chk(z_out == last_z, "R8", "result holds between strobes", z_out, last_z);
    run_iter(16'd2, 16'd5, 16'd1, 1'b0, z);
    chk(z == 16'd31, "R9", "history kept across idle", z, 16'd31);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    t_reset_state();
    t_fibonacci();
    t_random_stream();
    t_busy_ignored();
    t_wrap();
    t_mid_reset();
    t_idle_hold();
    finish_run();
  end

endmodule